// File: doc/BRIEF.md
# Embedded Logic Analyzer Capture Core

This block is a small on-chip logic analyzer. On every edge of the free-running system clock it looks at two groups of internal probe signals, an 8-bit group and a 1-bit group by default, each of its own parameterized width. Once armed by a host write, it keeps storing those samples into a circular sample memory until a trigger condition is seen. It then records a programmable number of further samples and stops with a done flag.

The trigger unit offers unsigned value comparisons against a constant (equal, not equal, less than, greater than) and edge detection on any chosen probe bit. A miss simply leaves the unit armed for the next cycle. An external trigger input can fire the capture, so the memory holds the activity leading up to an outside event. A trigger output is held high for a programmable number of cycles whenever the internal condition fires, so outside test equipment can start in step. A qualifier can restrict which post-trigger samples are kept.

The host side is a simple synchronous register port: writes take effect on the clock edge, and reads return, one cycle after the address is presented, the status, the trigger position or a stored sample selected by an index register. The sampling clock must be a fast free-running clock, never a slow divided one.

Top module: `elac_core`

## Requirements
- R1: After reset the status word reads 0 (idle, nothing triggered, not done) and trig_out is low.
- R2: Writing 1 to bit 0 of address 0x0 arms the core. Capture restarts at memory address 0, the status becomes armed (status bit 0), trig_out is cleared, and each armed cycle stores {probe_b, probe_a} at the next address, wrapping at DEPTH (a power of two).
- R3: Trigger mode 0 (address 0x1 bits [1:0]) compares the selected probe (bit [4]: 0 = probe_a, 1 = probe_b, zero-extended), unsigned, against address 0x2. The operator is set by bits [3:2]: 0 equal, 1 not equal, 2 less than, 3 greater than.
- R4: Trigger mode 1 fires on a rising edge and mode 2 on a falling edge of the selected probe bit (address 0x1 bits [9:5]). The current sample is compared with the previous one, so no edge is seen on the first armed cycle. Mode 3 disables the internal trigger.
- R5: While no trigger condition holds, the core stays armed and keeps storing samples every cycle.
- R6: Address 0x9 reads the memory address at which the trigger sample was stored.
- R7: After the trigger sample, the core stores exactly the count in address 0x4 (less than DEPTH-1) of further samples. It then shows done (status bit 2, with triggered bit 1 set and armed bit 0 clear) and writes nothing more. A count of 0 goes to done at once.
- R8: When the qualifier is enabled (address 0x3 bit 0), a post-trigger sample is stored only if probe_a bit [address 0x3 bits 6:2] equals the level in bit 1.
- R9: With address 0x1 bit 10 set, trig_in high in an armed cycle fires the capture. With that bit clear, trig_in has no effect.
- R10: An internal trigger drives trig_out high from the cycle after the firing edge for the count in address 0x5 (0 counts as 1). An external-only trigger leaves trig_out low.
- R11: A read returns the value at the addressed register one clock after the address is applied. Address 0x6 selects the sample index, and address 0xA returns that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling and register clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_a | input | WA | First probe group |
| probe_b | input | WB | Second probe group |
| trig_in | input | 1 | External trigger event |
| trig_out | output | 1 | Held high after an internal trigger |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Registered read data |

## Verification
Each operator of the value comparator is driven with long runs of non-matching values followed by one planted match. This separates a correct operator from a swapped or off-by-one one, and a late trigger position proves the ring wrap. The edge modes get a bit that is already high on the first armed cycle, which exposes an edge falsely seen against stale history, followed by a real edge later. An external-only run, a zero post count, a qualified capture and a re-arm during a long trigger-out pulse cover the remaining paths. Constrained-random runs with random operators, probe bits and qualifiers are scored against a bench model of the trigger and capture order.

// File: rtl/elac_core.sv
module elac_core #(
  parameter int WA    = 8,
  parameter int WB    = 1,
  parameter int DEPTH = 1024,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WA-1:0] probe_a,
  input  logic [WB-1:0] probe_b,
  input  logic          trig_in,
  output logic          trig_out,
  input  logic          host_wr,
  input  logic [3:0]    host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = WA + WB;
  localparam int MW = (WA > WB) ? WA : WB;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_POST, S_DONE} st_t;

  st_t              st;
  logic [1:0]       cfg_mode, cfg_op;
  logic             cfg_psel, cfg_ext;
  logic [4:0]       cfg_bit, q_bit;
  logic             q_en, q_lvl;
  logic [MW-1:0]    cmp_val;
  logic [CNT_W-1:0] post_cnt, hold_cnt, post_left, hold_left;
  logic [AW-1:0]    rd_idx, wptr, trig_pos;
  logic             prev_ok;
  logic [WA-1:0]    prev_a;
  logic [WB-1:0]    prev_b;
  logic [SW-1:0]    mem [DEPTH];

  logic          arm, cmp_hit, int_hit, fire, qual_ok, mem_we;
  logic          cur_bit, old_bit;
  logic [MW-1:0] cur_v, old_v, cur_sh, old_sh, q_sh;
  logic          unused_ok;

  assign arm     = host_wr && host_addr == 4'h0 && host_wdata[0];
  assign cur_v   = cfg_psel ? MW'(probe_b) : MW'(probe_a);
  assign old_v   = cfg_psel ? MW'(prev_b)  : MW'(prev_a);
  assign cur_sh  = cur_v >> cfg_bit;
  assign old_sh  = old_v >> cfg_bit;
  assign cur_bit = cur_sh[0];
  assign old_bit = old_sh[0];
  assign q_sh    = MW'(probe_a) >> q_bit;
  assign unused_ok = ^host_wdata;

  always_comb begin
    case (cfg_op)
      2'd0:    cmp_hit = cur_v == cmp_val;
      2'd1:    cmp_hit = cur_v != cmp_val;
      2'd2:    cmp_hit = cur_v <  cmp_val;
      default: cmp_hit = cur_v >  cmp_val;
    endcase
  end

  always_comb begin
    case (cfg_mode)
      2'd0:    int_hit = cmp_hit;
      2'd1:    int_hit = prev_ok &&  cur_bit && !old_bit;
      2'd2:    int_hit = prev_ok && !cur_bit &&  old_bit;
      default: int_hit = 1'b0;
    endcase
  end

  assign fire     = st == S_ARMED && (int_hit || (cfg_ext && trig_in));
  assign qual_ok  = !q_en || (q_sh[0] == q_lvl);
  assign mem_we   = !arm && (st == S_ARMED || (st == S_POST && qual_ok));
  assign trig_out = hold_left != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mode <= 2'd3; cfg_op <= '0; cfg_psel <= 1'b0; cfg_ext <= 1'b0;
      cfg_bit  <= '0;   cmp_val <= '0; q_en <= 1'b0; q_lvl <= 1'b0; q_bit <= '0;
      post_cnt <= '0;   hold_cnt <= '0; rd_idx <= '0;
    end else if (host_wr) begin
      case (host_addr)
        4'h1: begin
          cfg_mode <= host_wdata[1:0];
          cfg_op   <= host_wdata[3:2];
          cfg_psel <= host_wdata[4];
          cfg_bit  <= host_wdata[9:5];
          cfg_ext  <= host_wdata[10];
        end
        4'h2: cmp_val  <= host_wdata[MW-1:0];
        4'h3: begin
          q_en  <= host_wdata[0];
          q_lvl <= host_wdata[1];
          q_bit <= host_wdata[6:2];
        end
        4'h4: post_cnt <= host_wdata[CNT_W-1:0];
        4'h5: hold_cnt <= host_wdata[CNT_W-1:0];
        4'h6: rd_idx   <= host_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    prev_a <= probe_a;
    prev_b <= probe_b;
    if (mem_we) mem[wptr] <= {probe_b, probe_a};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; wptr <= '0; prev_ok <= 1'b0;
      hold_left <= '0; post_left <= '0; trig_pos <= '0;
    end else if (arm) begin
      st <= S_ARMED; wptr <= '0; prev_ok <= 1'b0; hold_left <= '0;
    end else begin
      if (mem_we) wptr <= wptr + 1'b1;
      prev_ok <= st == S_ARMED;
      if (fire && int_hit)
        hold_left <= (hold_cnt == '0) ? CNT_W'(1) : hold_cnt;
      else if (hold_left != '0)
        hold_left <= hold_left - 1'b1;
      case (st)
        S_ARMED: if (fire) begin
          trig_pos  <= wptr;
          post_left <= post_cnt;
          st        <= (post_cnt == '0) ? S_DONE : S_POST;
        end
        S_POST: if (qual_ok) begin
          post_left <= post_left - 1'b1;
          if (post_left == CNT_W'(1)) st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      case (host_addr)
        4'h8:    host_rdata <= 32'({st == S_DONE, st == S_POST || st == S_DONE, st == S_ARMED});
        4'h9:    host_rdata <= 32'(trig_pos);
        4'hA:    host_rdata <= 32'(mem[rd_idx]);
        default: host_rdata <= '0;
      endcase
    end
  end

  AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    arm |=> (st == S_ARMED && !trig_out && wptr == '0)); // R2
  AST_RING_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARMED && !arm) |=> wptr == AW'($past(wptr) + 1'b1)); // R5
  AST_TRIG_POS: assert property (@(posedge clk) disable iff (rst)
    (fire && !arm) |=> trig_pos == $past(wptr)); // R6
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE && !arm) |=> (st == S_DONE && $stable(wptr))); // R7
  AST_QUAL_SKIP: assert property (@(posedge clk) disable iff (rst)
    (st == S_POST && !arm && !qual_ok) |=> $stable(wptr)); // R8
  AST_TRIG_OUT_ON: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARMED && int_hit && !arm) |=> trig_out); // R10
endmodule

// File: tb/elac_core_bench.sv
module elac_core_bench;
  localparam int D = 16;
  localparam int N = 56;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  probe_a = '0;
  logic [0:0]  probe_b = '0;
  logic        trig_in = 1'b0;
  logic        trig_out;
  logic        host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  always #4 clk = ~clk;

  elac_core #(.WA(8), .WB(1), .DEPTH(D), .CNT_W(16)) u_elac_core (
    .clk(clk), .rst(rst), .probe_a(probe_a), .probe_b(probe_b),
    .trig_in(trig_in), .trig_out(trig_out), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0] stim_a [64];
  logic       stim_b [64];
  logic       stim_t [64];
  logic       to_rec [64];
  logic [1:0] mode, op;
  logic       psel, ext_en, qen, qlvl;
  logic [4:0] bitn, qbit;
  logic [7:0] cval;
  int         post, hold;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [31:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic rdmem(input int a, output logic [31:0] d);
    hwr(4'h6, 32'(a));
    hrd(4'hA, d);
  endtask

  task automatic cfg();
    hwr(4'h1, {21'b0, ext_en, bitn, psel, op, mode});
    hwr(4'h2, {24'b0, cval});
    hwr(4'h3, {25'b0, qbit, qlvl, qen});
    hwr(4'h4, 32'(post));
    hwr(4'h5, 32'(hold));
  endtask

  function automatic logic hit_at(input int k);
    logic [7:0] v, pv;
    v  = psel ? {7'b0, stim_b[k]} : stim_a[k];
    pv = (k == 0) ? 8'h0 : (psel ? {7'b0, stim_b[k-1]} : stim_a[k-1]);
    case (mode)
      2'd0: case (op)
              2'd0: return v == cval;
              2'd1: return v != cval;
              2'd2: return v < cval;
              default: return v > cval;
            endcase
      2'd1: return k > 0 && v[bitn[2:0]] && !pv[bitn[2:0]];
      2'd2: return k > 0 && !v[bitn[2:0]] && pv[bitn[2:0]];
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_trig();
    for (int k = 0; k < N; k++)
      if (hit_at(k) || (ext_en && stim_t[k])) return k;
    return -1;
  endfunction

  function automatic logic qual(input int k);
    logic [7:0] v;
    v = stim_a[k] >> qbit;
    return !qen || (v[0] == qlvl);
  endfunction

  function automatic int word(input int k);
    return int'({stim_b[k], stim_a[k]});
  endfunction

  task automatic run();
    hwr(4'h0, 32'h1);
    for (int k = 0; k < N; k++) begin
      probe_a = stim_a[k]; probe_b = stim_b[k]; trig_in = stim_t[k];
      @(negedge clk);
      to_rec[k] = trig_out;
    end
    probe_a = '0; probe_b = '0; trig_in = 1'b0;
  endtask

  task automatic fill_random();
    for (int k = 0; k < 64; k++) begin
      stim_a[k] = 8'($urandom);
      stim_b[k] = 1'($urandom);
      stim_t[k] = 1'($urandom);
    end
  endtask

  task automatic check_run(input string req, input bit must);
    int t, cnt, ea[8], ek[8], k2;
    bit reached, int_fired, bad;
    logic [31:0] d;
    t = exp_trig();
    if (!must && (t < 0 || t > 30)) return;
    cnt = 0;
    for (int k = t + 1; k < N; k++)
      if (cnt < post && qual(k)) begin
        ea[cnt] = (t + 1 + cnt) % D; ek[cnt] = k; cnt++;
      end
    reached = (cnt == post);
    if (!must && !reached) return;
    hrd(4'h9, d);
    chk({req, " R6 trigger position"}, int'(d), t % D);
    hrd(4'h8, d);
    chk({req, " R7 R11 status"}, int'(d), reached ? 6 : 2);
    rdmem(t % D, d);
    chk({req, " trigger sample"}, int'(d), word(t));
    for (int j = 0; j < cnt; j++) begin
      rdmem(ea[j], d);
      chk(qen ? {req, " R8 qualified post sample"} : {req, " R7 post sample"}, int'(d), word(ek[j]));
    end
    if (t >= 1) begin
      rdmem((t - 1) % D, d);
      chk({req, " R2 R5 pre-trigger sample"}, int'(d), word(t - 1));
    end
    k2 = t + post + 1 - D;
    if (k2 >= 0 && k2 < t) begin
      rdmem((t + post + 1) % D, d);
      chk({req, " R7 no write after done"}, int'(d), word(k2));
    end
    int_fired = hit_at(t);
    bad = 0;
    for (int k = 0; k < N; k++) begin
      logic e;
      e = int_fired && k >= t && k < t + ((hold == 0) ? 1 : hold);
      if (!bad && to_rec[k] != e) begin
        bad = 1;
        chk({req, " R10 trig_out cycle"}, int'(to_rec[k]), int'(e));
      end
    end
    if (!bad) chk({req, " R10 trig_out pulse"}, 0, 0);
  endtask

  task automatic defaults();
    mode = 2'd0; op = 2'd0; psel = 1'b0; ext_en = 1'b0; bitn = '0;
    cval = '0; qen = 1'b0; qlvl = 1'b0; qbit = '0; post = 4; hold = 2;
    fill_random();
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 trig_out after reset", int'(trig_out), 0);
    hrd(4'h8, d);
    chk("R1 status after reset", int'(d), 0);

    defaults(); cval = 8'hA5; post = 5; hold = 3;
    for (int k = 0; k < 22; k++) if (stim_a[k] == 8'hA5) stim_a[k] = 8'hA4;
    stim_a[22] = 8'hA5;
    cfg(); run(); check_run("R3 equal", 1);

    defaults(); op = 2'd1; cval = 8'h3C; post = 4; hold = 1;
    for (int k = 0; k < 18; k++) stim_a[k] = 8'h3C;
    stim_a[18] = 8'h3D;
    cfg(); run(); check_run("R3 not-equal R5", 1);

    defaults(); op = 2'd2; cval = 8'h10; post = 0; hold = 0;
    for (int k = 0; k < 25; k++) stim_a[k] = stim_a[k] | 8'h10;
    stim_a[25] = 8'h05;
    cfg(); run(); check_run("R3 less-than R7 zero post", 1);

    defaults(); op = 2'd3; psel = 1'b1; cval = 8'h0; post = 6; hold = 2;
    qen = 1'b1; qbit = 5'd3; qlvl = 1'b1;
    for (int k = 0; k < 20; k++) stim_b[k] = 1'b0;
    stim_b[20] = 1'b1;
    cfg(); run(); check_run("R3 greater-than probe_b R8", 1);

    defaults(); mode = 2'd1; bitn = 5'd6; post = 5; hold = 5; qen = 1'b1;
    for (int k = 0; k < 13; k++) stim_a[k] = stim_a[k] | 8'h40;
    for (int k = 13; k < 18; k++) stim_a[k] = stim_a[k] & 8'hBF;
    stim_a[18] = stim_a[18] | 8'h40;
    cfg(); run(); check_run("R4 rising not on first cycle", 1);

    defaults(); mode = 2'd2; psel = 1'b1; post = 3; hold = 4;
    for (int k = 0; k < 10; k++) stim_b[k] = 1'b1;
    stim_b[10] = 1'b0;
    cfg(); run(); check_run("R4 falling probe_b", 1);

    defaults(); mode = 2'd3; ext_en = 1'b1; post = 4; hold = 4;
    for (int k = 0; k < 64; k++) stim_t[k] = 1'b0;
    stim_t[27] = 1'b1;
    cfg(); run(); check_run("R9 external trigger", 1);

    defaults(); mode = 2'd1; bitn = 5'd0; post = 2; hold = 60;
    stim_a[0] = stim_a[0] & 8'hFE;
    stim_a[1] = stim_a[1] | 8'h01;
    cfg(); run();
    chk("R10 trig_out held at end of run", int'(trig_out), 1);
    hwr(4'h1, 32'h3);
    hwr(4'h0, 32'h1);
    chk("R10 trig_out cleared on arm", int'(trig_out), 0);
    hrd(4'h8, d);
    chk("R2 status armed after arm", int'(d), 1);

    for (int i = 0; i < 6; i++) begin
      defaults();
      mode = 2'($urandom % 3);
      op = 2'($urandom % 4);
      if (mode == 2'd0 && op == 2'd0) op = 2'd3;
      psel = 1'($urandom);
      bitn = psel ? 5'd0 : 5'($urandom % 8);
      cval = 8'($urandom);
      qen = 1'($urandom); qlvl = 1'($urandom); qbit = 5'($urandom % 8);
      post = 1 + int'($urandom % 6); hold = 1 + int'($urandom % 8);
      cfg(); run(); check_run("random R3 R4", 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule